// File: doc/BRIEF.md
# Dual-Descriptor-Set DMA Channel

This block is one DMA channel engine. Software programs it through a 32-bit register port. It moves data through a simple memory master port. Two descriptor sets each hold a source address, a destination address and a unit count. A command word starts the channel. In single mode the channel runs set 0 once and stops. In double mode the channel works through set 0, then set 1, then set 0 again, and so on. Software refills the set that is idle while the other one runs, so the stream never has to stall for software.

Data moves one unit at a time. A unit is 1, 2 or 4 bytes, chosen by two size fields in the control word. Each unit takes one read cycle and then one write cycle. Read data returns one cycle after the read request. The count of the running set counts down in place, so software can read how much work is left. When a set finishes, a sticky completion flag drives the interrupt line. A forced stop ends all activity at once and returns the queue to its first-start state.

Top module: `dsdma_chan`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and no memory request is issued.
- R2: Register offsets are as follows. Set 0 uses 0x00 (source), 0x04 (destination) and 0x08 (count). Set 1 uses 0x0C, 0x10 and 0x14. Other registers are 0x20 (remaining count), 0x28 (control), 0x2C (command), 0x30 (stop) and 0x34 (status). Set registers and the control word read back the value last written.
- R3: The unit size comes from the source size field (control bits 9:8) and the destination size field (control bits 1:0). The codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The two fields are used only when they are equal and not 3; in every other case the unit is 1 byte. Counts are in units. Both addresses advance by the unit's byte size after every unit.
- R4: In single mode (control bits 18 and 16 both 0), writing command bit 0 runs set 0. The channel copies `count` units and the set's count register falls to 0. Status bit 0 reads 1 from the start until the end.
- R5: If control bit 18 differs from control bit 16, the setting is invalid. Any start command is then ignored.
- R6: In double mode (control bits 18 and 16 both 1), the first start has command bit 1 clear. Every later start sets command bit 1. Accepted starts fill set 0, set 1, set 0, and so on, and the sets run in that same order. Status bit 2 reads 1 while any set is queued or running.
- R7: In double mode, the following starts are ignored: a first start with bit 1 set, a later start with bit 1 clear, and a start whose target set is still queued or running.
- R8: Command bit 2, written in double mode while a set is running, drops the waiting set. The queue then ends after the running set. The next start with bit 1 set targets the dropped set.
- R9: Writing 1 to bit 0 of the stop register halts the channel in the next cycle. It clears status bits 0 and 2 and does not raise `irq`. The next start is treated as a first start on set 0.
- R10: At launch, the count is limited to 16 MiB worth of units. That is 0x1000000 for 1-byte units and 0x400000 for 4-byte units.
- R11: Each finished set, including a set with count 0, sets the completion flag. A count-0 set moves no data. The flag drives `irq` and reads as status bit 8. Writing 1 to status bit 8 clears the flag; writing 0 there leaves it set.
- R12: Writes to a set's registers are ignored while that set is queued or running. Control writes are ignored while any set is queued or running. An accepted control write returns the queue to first-start state on set 0.
- R13: Offset 0x20 reads the remaining units of the set in progress. It reads 0 when no set is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Completion interrupt request |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Write data, in the low unit bytes |
| mem_wr_size | output | 2 | Write unit size code (0, 1 or 2) |

## Verification
The hardest states to reach are the double-mode queue states, where the two set pointers and the first-start flag must stay aligned. These are: a refused start while one set runs, an end-of-queue command while both sets are queued, and a stop in the middle of a set followed by a fresh start. The stimulus gives the first set a long count so that it is still running while the bench issues the second command. The bench checks the outcome only through memory contents and status reads. The 16 MiB limit is reached by writing a count above it, sampling the remaining count a few cycles after launch, and then stopping the channel.

// File: rtl/dsdma_pkg.sv
package dsdma_pkg;

  localparam logic [7:0] OFS_REMAIN = 8'h20;
  localparam logic [7:0] OFS_CTL    = 8'h28;
  localparam logic [7:0] OFS_CMD    = 8'h2C;
  localparam logic [7:0] OFS_STOP   = 8'h30;
  localparam logic [7:0] OFS_STAT   = 8'h34;
  localparam int SET_STRIDE = 12;

  localparam int CMD_GO   = 0;
  localparam int CMD_NEXT = 1;
  localparam int CMD_END  = 2;
  localparam int CTL_MODE_A = 18;
  localparam int CTL_MODE_B = 16;
  localparam int STAT_SINGLE = 0;
  localparam int STAT_QUEUE  = 2;
  localparam int STAT_DONE   = 8;

  typedef enum logic [1:0] {MV_IDLE, MV_LOAD, MV_READ, MV_WRITE} mv_state_e;

  // log2 of unit bytes: matching size fields, else byte units
  function automatic logic [1:0] unit_shift(input logic [31:0] c);
    logic [1:0] s, d;
    s = c[9:8];
    d = c[1:0];
    return (s == d && s != 2'd3) ? s : 2'd0;
  endfunction

  function automatic logic ctl_double(input logic [31:0] c);
    return c[CTL_MODE_A] & c[CTL_MODE_B];
  endfunction

  function automatic logic ctl_invalid(input logic [31:0] c);
    return c[CTL_MODE_A] ^ c[CTL_MODE_B];
  endfunction

  function automatic logic [31:0] max_units(input int log2_bytes, input logic [1:0] sh);
    return 32'd1 << (log2_bytes - int'(sh));
  endfunction

endpackage

// File: rtl/dsdma_regs.sv
module dsdma_regs
  import dsdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 25,
  parameter int MAX_LOG2 = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [1:0]        pending,
  input  logic              act,
  input  logic              load,
  input  logic              dec,
  input  logic              irq_flag,
  input  logic              stat_single,
  input  logic              stat_queue,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] src_act,
  output logic [ADDR_W-1:0] dst_act,
  output logic [CNT_W-1:0]  cnt_act,
  output logic [31:0]       ctl,
  output logic              cmd_wr,
  output logic              stop_wr,
  output logic              done_clr,
  output logic              ctl_wr
);

  function automatic logic [CNT_W-1:0] clamp_units(input logic [CNT_W-1:0] raw,
                                                   input logic [1:0] sh);
    logic [CNT_W-1:0] lim;
    lim = CNT_W'(max_units(MAX_LOG2, sh));
    return (raw > lim) ? lim : raw;
  endfunction

  assign cmd_wr   = reg_wr_en && reg_addr == OFS_CMD;
  assign stop_wr  = reg_wr_en && reg_addr == OFS_STOP && reg_wdata[0];
  assign done_clr = reg_wr_en && reg_addr == OFS_STAT && reg_wdata[STAT_DONE];
  assign ctl_wr   = reg_wr_en && reg_addr == OFS_CTL && pending == 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl <= '0;
    else if (ctl_wr) ctl <= reg_wdata;
  end

  for (genvar k = 0; k < 2; k++) begin : g_set
    localparam logic [7:0] BASE = 8'(k * SET_STRIDE);
    logic [ADDR_W-1:0] src_r, dst_r;
    logic [CNT_W-1:0]  cnt_r;
    logic              wr_ok, mine;
    assign wr_ok = reg_wr_en && !pending[k];
    assign mine  = (act == 1'(k));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_r <= '0;
        dst_r <= '0;
        cnt_r <= '0;
      end else begin
        if (wr_ok && reg_addr == BASE)        src_r <= reg_wdata[ADDR_W-1:0];
        if (wr_ok && reg_addr == BASE + 8'd4) dst_r <= reg_wdata[ADDR_W-1:0];
        if (load && mine)                     cnt_r <= clamp_units(cnt_r, unit_shift(ctl));
        else if (dec && mine)                 cnt_r <= cnt_r - CNT_W'(1);
        else if (wr_ok && reg_addr == BASE + 8'd8) cnt_r <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  assign src_act = act ? g_set[1].src_r : g_set[0].src_r;
  assign dst_act = act ? g_set[1].dst_r : g_set[0].dst_r;
  assign cnt_act = act ? g_set[1].cnt_r : g_set[0].cnt_r;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h00:      reg_rdata = 32'(g_set[0].src_r);
      8'h04:      reg_rdata = 32'(g_set[0].dst_r);
      8'h08:      reg_rdata = 32'(g_set[0].cnt_r);
      8'h0C:      reg_rdata = 32'(g_set[1].src_r);
      8'h10:      reg_rdata = 32'(g_set[1].dst_r);
      8'h14:      reg_rdata = 32'(g_set[1].cnt_r);
      OFS_REMAIN: reg_rdata = pending[act] ? 32'(cnt_act) : 32'd0;
      OFS_CTL:    reg_rdata = ctl;
      OFS_STAT: begin
        reg_rdata[STAT_SINGLE] = stat_single;
        reg_rdata[STAT_QUEUE]  = stat_queue;
        reg_rdata[STAT_DONE]   = irq_flag;
      end
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dsdma_queue.sv
module dsdma_queue
  import dsdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [2:0] cmd_bits,
  input  logic       stop_wr,
  input  logic       ctl_wr,
  input  logic       done_clr,
  input  logic       dbl,
  input  logic       cfg_bad,
  input  logic       set_done,
  input  logic       mover_idle,
  output logic [1:0] pending,
  output logic       act,
  output logic       launch,
  output logic       irq_flag,
  output logic       stat_single,
  output logic       stat_queue,
  output logic       start_ok
);

  logic wr_sel, first;
  logic go, nxt, end_req, end_ok, tgt;

  assign go      = cmd_wr && cmd_bits[CMD_GO] && !cmd_bits[CMD_END];
  assign nxt     = cmd_bits[CMD_NEXT];
  assign end_req = cmd_wr && cmd_bits[CMD_END];
  assign tgt     = dbl ? wr_sel : 1'b0;

  always_comb begin
    start_ok = 1'b0;
    if (go && !cfg_bad) begin
      if (!dbl)       start_ok = !pending[0];
      else if (first) start_ok = !nxt && !pending[wr_sel];
      else            start_ok = nxt && !pending[wr_sel];
    end
  end

  assign end_ok      = end_req && dbl && pending[act] && !set_done;
  assign launch      = mover_idle && pending[act] && !stop_wr;
  assign stat_single = !dbl && pending[0];
  assign stat_queue  = dbl && (pending != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n || stop_wr || ctl_wr) begin
      pending <= '0;
      act     <= 1'b0;
      wr_sel  <= 1'b0;
      first   <= 1'b1;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (set_done && act == 1'(k))         pending[k] <= 1'b0;
        else if (start_ok && tgt == 1'(k))    pending[k] <= 1'b1;
        else if (end_ok && act != 1'(k))      pending[k] <= 1'b0;
      end
      if (set_done && dbl) act <= ~act;
      if (end_ok)                wr_sel <= ~act;
      else if (start_ok && dbl)  wr_sel <= ~wr_sel;
      if (start_ok && dbl) first <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        irq_flag <= 1'b0;
    else if (set_done) irq_flag <= 1'b1;
    else if (done_clr) irq_flag <= 1'b0;
  end

endmodule

// File: rtl/dsdma_mover.sv
module dsdma_mover
  import dsdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              launch,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_cur,
  input  logic [1:0]        shift,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic [1:0]        mem_wr_size,
  output logic              load,
  output logic              unit_done,
  output logic              set_done,
  output logic              idle
);

  mv_state_e state_q, state_d;
  logic [ADDR_W-1:0] src_w, dst_w, step;

  assign step        = ADDR_W'(1) << shift;
  assign mem_rd_addr = src_w;
  assign mem_wr_addr = dst_w;
  assign mem_wr_data = mem_rd_data;
  assign mem_wr_size = shift;

  always_comb begin
    state_d   = state_q;
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    load      = 1'b0;
    unit_done = 1'b0;
    set_done  = 1'b0;
    idle      = 1'b0;
    case (state_q)
      MV_IDLE: begin
        idle = 1'b1;
        if (launch && !abort) state_d = MV_LOAD;
      end
      MV_LOAD: begin
        if (abort) state_d = MV_IDLE;
        else begin
          load = 1'b1;
          if (cnt_cur == '0) begin
            set_done = 1'b1;
            state_d  = MV_IDLE;
          end else state_d = MV_READ;
        end
      end
      MV_READ: begin
        mem_rd_en = !abort;
        state_d   = abort ? MV_IDLE : MV_WRITE;
      end
      MV_WRITE: begin
        if (abort) state_d = MV_IDLE;
        else begin
          mem_wr_en = 1'b1;
          unit_done = 1'b1;
          if (cnt_cur == CNT_W'(1)) begin
            set_done = 1'b1;
            state_d  = MV_IDLE;
          end else state_d = MV_READ;
        end
      end
      default: state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      src_w   <= '0;
      dst_w   <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        src_w <= src_in;
        dst_w <= dst_in;
      end else if (unit_done) begin
        src_w <= src_w + step;
        dst_w <= dst_w + step;
      end
    end
  end

endmodule

// File: rtl/dsdma_chan.sv
module dsdma_chan
  import dsdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 24,
  localparam int CNT_W   = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic [1:0]        mem_wr_size
);

  logic [1:0]        pending;
  logic              act, load, unit_done, set_done, mover_idle, launch;
  logic              irq_flag, stat_single, stat_queue, start_ok;
  logic              cmd_wr, stop_wr, done_clr, ctl_wr;
  logic [31:0]       ctl;
  logic [ADDR_W-1:0] src_act, dst_act;
  logic [CNT_W-1:0]  cnt_act;
  logic              dbl, cfg_bad, go_on_bad_cfg;

  assign dbl           = ctl_double(ctl);
  assign cfg_bad       = ctl_invalid(ctl);
  assign go_on_bad_cfg = cmd_wr && reg_wdata[CMD_GO] && cfg_bad;
  assign irq           = irq_flag;

  dsdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_LOG2(MAX_LOG2)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pending(pending), .act(act), .load(load),
    .dec(unit_done), .irq_flag(irq_flag), .stat_single(stat_single),
    .stat_queue(stat_queue), .reg_rdata(reg_rdata), .src_act(src_act),
    .dst_act(dst_act), .cnt_act(cnt_act), .ctl(ctl), .cmd_wr(cmd_wr),
    .stop_wr(stop_wr), .done_clr(done_clr), .ctl_wr(ctl_wr)
  );

  dsdma_queue u_queue (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bits(reg_wdata[2:0]),
    .stop_wr(stop_wr), .ctl_wr(ctl_wr), .done_clr(done_clr), .dbl(dbl),
    .cfg_bad(cfg_bad), .set_done(set_done), .mover_idle(mover_idle),
    .pending(pending), .act(act), .launch(launch), .irq_flag(irq_flag),
    .stat_single(stat_single), .stat_queue(stat_queue), .start_ok(start_ok)
  );

  dsdma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .abort(stop_wr), .launch(launch),
    .src_in(src_act), .dst_in(dst_act), .cnt_cur(cnt_act),
    .shift(unit_shift(ctl)), .mem_rd_data(mem_rd_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_size(mem_wr_size), .load(load), .unit_done(unit_done),
    .set_done(set_done), .idle(mover_idle)
  );

endmodule

// File: rtl/dsdma_chk.sv
module dsdma_chk #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic             unit_done,
  input logic             set_done,
  input logic [CNT_W-1:0] cnt_act,
  input logic [1:0]       pending,
  input logic             irq,
  input logic             stop_wr,
  input logic             go_on_bad_cfg,
  input logic             dbl,
  input logic             start_ok
);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R4

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en)); // R4

  AST_UNIT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !set_done) |=> (cnt_act + CNT_W'(1)) == $past(cnt_act)); // R4

  AST_SINGLE_USES_SET0: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |-> !pending[1]); // R4

  AST_BAD_CFG_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    go_on_bad_cfg |-> !start_ok); // R5

  AST_STOP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> pending == 2'b00); // R9

  AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_done)); // R11

endmodule

bind dsdma_chan dsdma_chk #(.CNT_W(CNT_W)) i_dsdma_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .unit_done(unit_done), .set_done(set_done), .cnt_act(cnt_act),
  .pending(pending), .irq(irq), .stop_wr(stop_wr),
  .go_on_bad_cfg(go_on_bad_cfg), .dbl(dbl), .start_ok(start_ok)
);

// File: tb/test_dsdma_chan.sv
module test_dsdma_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic [31:0] mem_rd_data = '0;
  logic [1:0]  mem_wr_size;

  logic [7:0] mem  [1024];
  logic [7:0] refm [1024];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  dsdma_chan i_dsdma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_size(mem_wr_size)
  );

  always @(posedge clk) begin
    if (mem_rd_en)
      mem_rd_data <= {mem[mem_rd_addr[9:0] + 10'd3], mem[mem_rd_addr[9:0] + 10'd2],
                      mem[mem_rd_addr[9:0] + 10'd1], mem[mem_rd_addr[9:0]]};
    if (mem_wr_en)
      for (int b = 0; b < (1 << mem_wr_size); b++)
        mem[mem_wr_addr[9:0] + 10'(b)] <= mem_wr_data[8*b +: 8];
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-run act=%0d exp=%0d", cyc, 0);
      report();
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, a, e);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ad, output logic [31:0] d);
    @(negedge clk);
    reg_addr = ad;
    #1 d = reg_rdata;
  endtask

  task automatic prog(input int k, input int s, input int d, input int c);
    wr(8'(k*12),     32'(s));
    wr(8'(k*12 + 4), 32'(d));
    wr(8'(k*12 + 8), 32'(c));
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] st;
    int n = 0;
    do begin
      rd(8'h34, st);
      n++;
    end while ((st[0] || st[2]) && n < 4000);
    chk(n < 4000, req, st, 32'h0);
  endtask

  task automatic expect_copy(input int s, input int d, input int bytes);
    for (int i = 0; i < bytes; i++) refm[(d + i) % 1024] = refm[(s + i) % 1024];
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refm[i]) bad++;
    chk(bad == 0, req, 32'(bad), 32'h0);
  endtask

  task automatic sync_ref();
    for (int i = 0; i < 1024; i++) refm[i] = mem[i];
  endtask

  function automatic logic [31:0] sctl(input int s);
    return (32'(s) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] dctl(input int s);
    return sctl(s) | (32'd1 << 18) | (32'd1 << 16);
  endfunction

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'($urandom);
      refm[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h34, d); chk(d == 0, "R1 status", d, 0);
    rd(8'h08, d); chk(d == 0, "R1 count0", d, 0);
    chk(irq == 0 && !mem_rd_en && !mem_wr_en, "R1 outputs", {irq, mem_rd_en, mem_wr_en}, 0);

    // R2 readback
    wr(8'h28, sctl(1)); rd(8'h28, d); chk(d == sctl(1), "R2 ctl", d, sctl(1));
    wr(8'h0C, 32'h1234_5678); rd(8'h0C, d); chk(d == 32'h1234_5678, "R2 set1 src", d, 32'h1234_5678);

    // R4 single byte transfer, R13 remaining count, R12 protection
    wr(8'h28, sctl(0));
    prog(0, 16, 528, 60); expect_copy(16, 528, 60);
    wr(8'h2C, 32'h1);
    rd(8'h34, d); chk(d[0] == 1'b1, "R4 busy bit", d, 1);
    rd(8'h20, d); chk(d > 0 && d <= 60, "R13 remaining", d, 60);
    wr(8'h00, 32'hDEAD); rd(8'h00, d); chk(d == 16, "R12 src protected", d, 16);
    wr(8'h28, dctl(0)); rd(8'h28, d); chk(d == sctl(0), "R12 ctl protected", d, sctl(0));
    wait_idle("R4 finish");
    cmp_mem("R4 data");
    rd(8'h08, d); chk(d == 0, "R4 count zero", d, 0);
    rd(8'h20, d); chk(d == 0, "R13 idle remaining", d, 0);
    chk(irq == 1, "R11 irq set", irq, 1);

    // R11 clear semantics
    wr(8'h34, 32'h0); chk(irq == 1, "R11 write0 keeps", irq, 1);
    wr(8'h34, 32'h100); chk(irq == 0, "R11 w1c", irq, 0);

    // R11 zero count
    prog(0, 40, 600, 0);
    wr(8'h2C, 32'h1);
    repeat (4) @(negedge clk);
    chk(irq == 1, "R11 zero count done", irq, 1);
    cmp_mem("R11 zero count no data");
    wr(8'h34, 32'h100);

    // R3 size mismatch falls back to bytes; 16-bit and 32-bit
    wr(8'h28, (32'd2 << 8));
    prog(0, 64, 640, 6); expect_copy(64, 640, 6);
    wr(8'h2C, 32'h1); wait_idle("R3 mismatch"); cmp_mem("R3 mismatch bytes");
    wr(8'h28, sctl(2));
    prog(0, 100, 700, 5); expect_copy(100, 700, 20);
    wr(8'h2C, 32'h1); wait_idle("R3 word"); cmp_mem("R3 word units");

    // R5 invalid mode
    wr(8'h34, 32'h100);
    wr(8'h28, 32'd1 << 18);
    prog(0, 120, 800, 8);
    wr(8'h2C, 32'h1);
    repeat (10) @(negedge clk);
    rd(8'h34, d); chk(d == 0, "R5 no start", d, 0);
    cmp_mem("R5 no data");

    // R3 random single transfers
    for (int it = 0; it < 8; it++) begin
      int sh, cnt, s, dd;
      sh  = int'($urandom % 3);
      cnt = 1 + int'($urandom % 16);
      s   = int'($urandom % 64) * 4;
      dd  = 512 + int'($urandom % 64) * 4;
      wr(8'h28, sctl(sh));
      prog(0, s, dd, cnt); expect_copy(s, dd, cnt << sh);
      wr(8'h2C, 32'h1); wait_idle("R3 random");
      cmp_mem("R3 random data");
    end

    // R6 double mode alternation
    wr(8'h28, dctl(2));
    prog(0, 0, 512, 4); expect_copy(0, 512, 16);
    wr(8'h2C, 32'h1);
    rd(8'h34, d); chk(d[2] == 1'b1, "R6 queue bit", d, 4);
    prog(1, 32, 560, 4); expect_copy(32, 560, 16);
    wr(8'h2C, 32'h3);
    wait_idle("R6 drain"); cmp_mem("R6 both sets");
    prog(0, 64, 600, 3); expect_copy(64, 600, 12);
    wr(8'h2C, 32'h3);
    wait_idle("R6 third"); cmp_mem("R6 back to set0");

    // R7 refusals
    wr(8'h28, dctl(0));
    prog(0, 200, 900, 40);
    wr(8'h2C, 32'h3);
    repeat (6) @(negedge clk);
    rd(8'h34, d); chk(d[2] == 0, "R7 first with next", d, 0);
    expect_copy(200, 900, 40);
    wr(8'h2C, 32'h1);
    prog(1, 260, 960, 8);
    wr(8'h2C, 32'h1);
    wait_idle("R7 drain"); cmp_mem("R7 later without next");

    // R8 end of queue
    wr(8'h28, dctl(0));
    prog(0, 300, 520, 40); expect_copy(300, 520, 40);
    wr(8'h2C, 32'h1);
    prog(1, 360, 580, 8);
    wr(8'h2C, 32'h3);
    wr(8'h2C, 32'h4);
    wait_idle("R8 drain"); cmp_mem("R8 waiting set dropped");
    expect_copy(360, 580, 8);
    wr(8'h2C, 32'h3);
    wait_idle("R8 resume"); cmp_mem("R8 dropped set runs later");

    // R9 forced stop
    wr(8'h34, 32'h100);
    wr(8'h28, dctl(0));
    prog(0, 0, 512, 200);
    wr(8'h2C, 32'h1);
    repeat (30) @(negedge clk);
    wr(8'h30, 32'h1);
    rd(8'h34, d); chk(d == 0, "R9 status cleared", d, 0);
    rd(8'h20, d); chk(d == 0, "R9 no remaining", d, 0);
    rd(8'h08, d); chk(d > 0 && d < 200, "R9 partial count", d, 100);
    chk(irq == 0, "R9 no irq", irq, 0);
    sync_ref();
    prog(0, 400, 700, 4); expect_copy(400, 700, 4);
    wr(8'h2C, 32'h1);
    wait_idle("R9 restart"); cmp_mem("R9 first start after stop");

    // R10 clamp
    wr(8'h28, sctl(2));
    prog(0, 0, 512, 32'h01FF_FFFF);
    wr(8'h2C, 32'h1);
    repeat (3) @(negedge clk);
    rd(8'h20, d); chk(d <= 32'h40_0000 && d >= 32'h40_0000 - 16, "R10 word clamp", d, 32'h40_0000);
    wr(8'h30, 32'h1);
    wr(8'h28, sctl(0));
    prog(0, 0, 512, 32'h01FF_FFFF);
    wr(8'h2C, 32'h1);
    repeat (3) @(negedge clk);
    rd(8'h20, d); chk(d <= 32'h100_0000 && d >= 32'h100_0000 - 16, "R10 byte clamp", d, 32'h100_0000);
    wr(8'h30, 32'h1);

    report();
  end

endmodule